// File: doc/BRIEF.md
# Bridge I/O Forwarding Decoder

This block is the control side of a host-to-link bridge port. It keeps the bridge control word and a 4 KB-granular I/O window (base and limit). For every processor I/O cycle it decides, in the same cycle, whether the access goes down to the link or stays on the legacy decode path. Two legacy rules change the window decode. ISA mode removes the upper three quarters of every 1 KB block from the window. VGA mode forwards the VGA register ranges, matched on either 10 or 16 address bits.

The block also has two error paths. Error messages arriving from the secondary side are gated into a system-error request. A poisoned read-data completion sets a sticky master data parity error flag. The secondary-bus-reset control bit is driven out as a hot-reset request to the link state machine.

All pins are plain control and status signals. The I/O decode is combinational, and the block never applies back-pressure: an access offered with `io_valid` is routed in that cycle and nothing is held.

Top module: `bridge_io_decoder`

## Requirements
- R1: After reset, all writable control bits of `ctl_rdata` read 0, `win_base_q` reads all ones, `win_limit_q` reads 0, and `perr_sts`, `serr_req` and `hot_rst_req` are 0.
- R2: The control word places bits as follows: bit 0 is parity response enable, bit 1 is SERR enable, bit 2 is ISA enable, bit 3 is VGA enable, bit 4 is VGA 16-bit decode and bit 6 is secondary bus reset. Bits 5, 7, 8, 9 and 15:10 always read 0, whatever is written to them. A write takes effect at the next clock edge.
- R3: With ISA enable and VGA enable clear, an address is routed to the link exactly when its bits [15:12] lie in base..limit. The window is empty when base > limit.
- R4: With ISA enable set, a window address whose bits [9:8] are not both 0 is not routed to the link, unless R5 forwards it.
- R5: With VGA enable set, addresses whose low 10 bits are in 3B0h–3BBh or 3C0h–3DFh go to the link, regardless of the window or ISA. With VGA 16-bit decode set, bits [15:10] must also be 0. With VGA enable clear, the 16-bit decode bit has no effect.
- R6: `route_legacy` is `io_valid` and not link. Both outputs are 0 while `io_valid` is 0.
- R7: `serr_req` is 1 in the cycle after an error message (class 0 correctable, 1 non-fatal, 2 fatal; class 3 ignored) exactly when SERR enable and `err_class_en[class]` are both 1.
- R8: `perr_sts` is set one cycle after `cpl_poison` only when parity response enable is 1. It holds until `perr_sts_clr`. If a set and a clear arrive in the same cycle, the bit stays set.
- R9: `hot_rst_req` equals the stored secondary bus reset bit. It rises the cycle after that bit is written to 1 and falls the cycle after it is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control word readback |
| win_we | input | 1 | Write strobe for base and limit |
| win_base_wd | input | 4 | New window base (address bits 15:12) |
| win_limit_wd | input | 4 | New window limit (address bits 15:12) |
| win_base_q | output | 4 | Stored window base |
| win_limit_q | output | 4 | Stored window limit |
| io_valid | input | 1 | Processor I/O cycle present |
| io_addr | input | 16 | Processor I/O address |
| route_link | output | 1 | Forward the access to the link |
| route_legacy | output | 1 | Send the access to the legacy path |
| err_msg_valid | input | 1 | Error message received from the secondary side |
| err_msg_class | input | 2 | Message class: 0 correctable, 1 non-fatal, 2 fatal |
| err_class_en | input | 3 | Per-class system-error enables |
| serr_req | output | 1 | System-error request |
| cpl_poison | input | 1 | Poisoned read-data completion received upstream |
| perr_sts_clr | input | 1 | Write-one-to-clear for the parity flag |
| perr_sts | output | 1 | Master data parity error status |
| hot_rst_req | output | 1 | Hot-reset request to the link state machine |

## Verification
A wrong stored control bit or window bound shows in the same cycle as a misrouted address. Because of this, the bench sweeps all 65536 addresses under several control and window settings and compares each one with an arithmetic model. A lost or wrongly set parity flag, or a wrong system-error gate, shows one cycle after the triggering pulse. The bench checks those outputs at exactly that cycle and again one cycle later, to confirm that the flag stays set and the request does not linger. A fault in the control register shows at once on `ctl_rdata`, including any read-only bit that wrongly stores a write.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int CTL_W        = 16;
  localparam int B_PERR_EN    = 0;
  localparam int B_SERR_EN    = 1;
  localparam int B_ISA_EN     = 2;
  localparam int B_VGA_EN     = 3;
  localparam int B_VGA16      = 4;
  localparam int B_SBR        = 6;
  localparam int N_ERR_CLASS  = 3;

  typedef struct packed {
    logic sbr;
    logic vga16;
    logic vga_en;
    logic isa_en;
    logic serr_en;
    logic perr_en;
  } brg_ctl_t;

  function automatic logic [CTL_W-1:0] pack_ctl(brg_ctl_t c);
    logic [CTL_W-1:0] w;
    w = '0;
    w[B_PERR_EN] = c.perr_en;
    w[B_SERR_EN] = c.serr_en;
    w[B_ISA_EN]  = c.isa_en;
    w[B_VGA_EN]  = c.vga_en;
    w[B_VGA16]   = c.vga16;
    w[B_SBR]     = c.sbr;
    return w;
  endfunction
endpackage

// File: rtl/brg_ctl_regs.sv
module brg_ctl_regs
  import brg_pkg::*;
#(
  parameter int WIN_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_wdata,
  input  logic                 win_we,
  input  logic [WIN_W-1:0]     win_base_wd,
  input  logic [WIN_W-1:0]     win_limit_wd,
  output brg_ctl_t             ctl_q,
  output logic [CTL_W-1:0]     ctl_rdata,
  output logic [WIN_W-1:0]     base_q,
  output logic [WIN_W-1:0]     limit_q
);
  logic unused_ro_bits;
  assign unused_ro_bits = ^{ctl_wdata[CTL_W-1:B_SBR+1], ctl_wdata[B_VGA16+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q.perr_en <= ctl_wdata[B_PERR_EN];
      ctl_q.serr_en <= ctl_wdata[B_SERR_EN];
      ctl_q.isa_en  <= ctl_wdata[B_ISA_EN];
      ctl_q.vga_en  <= ctl_wdata[B_VGA_EN];
      ctl_q.vga16   <= ctl_wdata[B_VGA16];
      ctl_q.sbr     <= ctl_wdata[B_SBR];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '1;
      limit_q <= '0;
    end else if (win_we) begin
      base_q  <= win_base_wd;
      limit_q <= win_limit_wd;
    end
  end

  assign ctl_rdata = pack_ctl(ctl_q);

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[B_ISA_EN] == $past(ctl_wdata[B_ISA_EN]))); // R2
  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_rdata)); // R2
endmodule

// File: rtl/brg_io_route.sv
module brg_io_route
  import brg_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int WIN_W   = 4,
  parameter int BLK_W   = 10,
  parameter int CARVE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  brg_ctl_t          ctl,
  input  logic [WIN_W-1:0]  base_q,
  input  logic [WIN_W-1:0]  limit_q,
  input  logic              io_valid,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              route_link,
  output logic              route_legacy
);
  localparam int WIN_LSB = ADDR_W - WIN_W;

  logic [WIN_W-1:0]  page;
  logic [BLK_W-1:0]  blk_off;
  logic              win_open, in_win, carve, vga_lo, vga_hi_ok, vga_hit;

  assign page     = io_addr[ADDR_W-1:WIN_LSB];
  assign blk_off  = io_addr[BLK_W-1:0];
  assign win_open = (base_q <= limit_q);
  assign in_win   = win_open && (page >= base_q) && (page <= limit_q);
  assign carve    = ctl.isa_en && (io_addr[BLK_W-1:BLK_W-CARVE_W] != '0);

  assign vga_lo = ((blk_off >= BLK_W'(12'h3B0)) && (blk_off <= BLK_W'(12'h3BB))) ||
                  ((blk_off >= BLK_W'(12'h3C0)) && (blk_off <= BLK_W'(12'h3DF)));

  generate
    if (ADDR_W > BLK_W) begin : g_hi
      assign vga_hi_ok = !ctl.vga16 || (io_addr[ADDR_W-1:BLK_W] == '0);
    end else begin : g_nohi
      assign vga_hi_ok = 1'b1;
    end
  endgenerate

  assign vga_hit = ctl.vga_en && vga_lo && vga_hi_ok;

  always_comb begin
    route_link   = 1'b0;
    route_legacy = 1'b0;
    if (io_valid) begin
      route_link   = vga_hit || (in_win && !carve);
      route_legacy = !route_link;
    end
  end

  AST_EMPTY_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && (base_q > limit_q) && !vga_hit) |-> !route_link); // R3
  AST_ISA_CARVE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && carve && !vga_hit) |-> !route_link); // R4
  AST_VGA_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && vga_hit) |-> route_link); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> !(route_link || route_legacy)); // R6
endmodule

// File: rtl/brg_err_gate.sv
module brg_err_gate
  import brg_pkg::*;
#(
  parameter int NCLS  = N_ERR_CLASS,
  parameter int CLS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  brg_ctl_t         ctl,
  input  logic             err_msg_valid,
  input  logic [CLS_W-1:0] err_msg_class,
  input  logic [NCLS-1:0]  err_class_en,
  input  logic             cpl_poison,
  input  logic             perr_sts_clr,
  output logic             serr_req,
  output logic             perr_sts
);
  logic [NCLS-1:0] cls_hit;

  generate
    for (genvar i = 0; i < NCLS; i++) begin : g_cls
      assign cls_hit[i] = err_msg_valid && (err_msg_class == CLS_W'(i)) && err_class_en[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_req <= 1'b0;
    else        serr_req <= ctl.serr_en && (|cls_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        perr_sts <= 1'b0;
    else if (cpl_poison && ctl.perr_en) perr_sts <= 1'b1;
    else if (perr_sts_clr)              perr_sts <= 1'b0;
  end

  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.serr_en |=> !serr_req); // R7
  AST_SERR_NOMSG: assert property (@(posedge clk) disable iff (!rst_n)
    !err_msg_valid |=> !serr_req); // R7
  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_sts && !perr_sts_clr) |=> perr_sts); // R8
  AST_PERR_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_sts && !(cpl_poison && ctl.perr_en)) |=> !perr_sts); // R8
endmodule

// File: rtl/bridge_io_decoder.sv
module bridge_io_decoder
  import brg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [15:0]       ctl_wdata,
  output logic [15:0]       ctl_rdata,
  input  logic              win_we,
  input  logic [WIN_W-1:0]  win_base_wd,
  input  logic [WIN_W-1:0]  win_limit_wd,
  output logic [WIN_W-1:0]  win_base_q,
  output logic [WIN_W-1:0]  win_limit_q,
  input  logic              io_valid,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              route_link,
  output logic              route_legacy,
  input  logic              err_msg_valid,
  input  logic [1:0]        err_msg_class,
  input  logic [2:0]        err_class_en,
  output logic              serr_req,
  input  logic              cpl_poison,
  input  logic              perr_sts_clr,
  output logic              perr_sts,
  output logic              hot_rst_req
);
  brg_ctl_t ctl_q;

  brg_ctl_regs #(.WIN_W(WIN_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .win_we(win_we), .win_base_wd(win_base_wd), .win_limit_wd(win_limit_wd),
    .ctl_q(ctl_q), .ctl_rdata(ctl_rdata), .base_q(win_base_q), .limit_q(win_limit_q)
  );

  brg_io_route #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) route_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .base_q(win_base_q), .limit_q(win_limit_q),
    .io_valid(io_valid), .io_addr(io_addr),
    .route_link(route_link), .route_legacy(route_legacy)
  );

  brg_err_gate #(.NCLS(3), .CLS_W(2)) err_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_q),
    .err_msg_valid(err_msg_valid), .err_msg_class(err_msg_class),
    .err_class_en(err_class_en), .cpl_poison(cpl_poison),
    .perr_sts_clr(perr_sts_clr), .serr_req(serr_req), .perr_sts(perr_sts)
  );

  assign hot_rst_req = ctl_q.sbr;

  AST_HOTRST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[B_SBR]) |=> hot_rst_req); // R9
  AST_HOTRST_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[B_SBR]) |=> !hot_rst_req); // R9
  AST_RO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[9:7] == 3'b000) && !ctl_rdata[5]); // R2
endmodule

// File: tb/bridge_io_decoder_tb_top.sv
`timescale 1ns/1ps
module bridge_io_decoder_tb_top;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, win_we = 0, io_valid = 0;
  logic [15:0] ctl_wdata = 0, ctl_rdata, io_addr = 0;
  logic [3:0] win_base_wd = 0, win_limit_wd = 0, win_base_q, win_limit_q;
  logic route_link, route_legacy, serr_req, perr_sts, hot_rst_req;
  logic err_msg_valid = 0, cpl_poison = 0, perr_sts_clr = 0;
  logic [1:0] err_msg_class = 0;
  logic [2:0] err_class_en = 0;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  bridge_io_decoder dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr_ctl(logic [15:0] v);
    @(negedge clk); ctl_we = 1; ctl_wdata = v;
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic wr_win(int b, int l);
    @(negedge clk); win_we = 1; win_base_wd = 4'(b); win_limit_wd = 4'(l);
    @(negedge clk); win_we = 0;
  endtask

  function automatic bit exp_link(int a, bit isa, bit vga, bit v16, int b, int l);
    bit in_win, carve, vr;
    int lo;
    in_win = (b <= l) && ((a >> 12) >= b) && ((a >> 12) <= l);
    carve  = isa && (((a >> 8) & 3) != 0);
    lo = a & 'h3FF;
    vr = ((lo >= 'h3B0) && (lo <= 'h3BB)) || ((lo >= 'h3C0) && (lo <= 'h3DF));
    if (v16) vr = vr && ((a >> 10) == 0);
    return (vga && vr) || (in_win && !carve);
  endfunction

  task automatic sweep(string req, bit isa, bit vga, bit v16, int b, int l);
    wr_ctl({11'd0, v16, vga, isa, 2'b00});
    wr_win(b, l);
    io_valid = 1;
    for (int a = 0; a < 65536; a++) begin
      bit e;
      io_addr = 16'(a);
      #1;
      e = exp_link(a, isa, vga, v16, b, l);
      chk(req, route_link, e);
      chk("R6", route_legacy, !e);
    end
    io_valid = 0;
  endtask

  initial begin
    #9 rst_n = 1;
    @(negedge clk);
    chk("R1", ctl_rdata, 0);
    chk("R1", win_base_q, 'hF);
    chk("R1", win_limit_q, 0);
    chk("R1", {perr_sts, serr_req, hot_rst_req}, 0);

    wr_ctl(16'hFFFF);
    chk("R2", ctl_rdata, 16'h005F);
    chk("R9", hot_rst_req, 1);
    wr_ctl(16'hFFA0);
    chk("R2", ctl_rdata, 0);
    chk("R9", hot_rst_req, 0);

    io_valid = 0;
    for (int a = 0; a < 1024; a++) begin
      io_addr = 16'(a * 61); #1;
      chk("R6", {route_link, route_legacy}, 0);
    end

    sweep("R3", 0, 0, 0, 1, 2);
    sweep("R3", 0, 0, 1, 5, 2);
    sweep("R4", 1, 0, 0, 0, 15);
    sweep("R5", 1, 1, 0, 3, 3);
    sweep("R5", 0, 1, 1, 8, 9);

    // R7: gating of error messages
    for (int s = 0; s < 2; s++) begin
      for (int en = 0; en < 8; en++) begin
        for (int c = 0; c < 4; c++) begin
          wr_ctl(16'(s << 1));
          @(negedge clk);
          err_msg_valid = 1; err_msg_class = 2'(c); err_class_en = 3'(en);
          @(negedge clk);
          err_msg_valid = 0;
          chk("R7", serr_req, (s == 1) && (c < 3) && (((en >> c) & 1) == 1));
          @(negedge clk);
          chk("R7", serr_req, 0);
        end
      end
    end

    // R8: poisoned completion, sticky flag, clear, set-wins
    wr_ctl(16'h0000);
    cpl_poison = 1; @(negedge clk); cpl_poison = 0;
    chk("R8", perr_sts, 0);
    wr_ctl(16'h0001);
    cpl_poison = 1; @(negedge clk); cpl_poison = 0;
    chk("R8", perr_sts, 1);
    repeat (3) @(negedge clk);
    chk("R8", perr_sts, 1);
    cpl_poison = 1; perr_sts_clr = 1; @(negedge clk);
    cpl_poison = 0; perr_sts_clr = 0;
    chk("R8", perr_sts, 1);
    perr_sts_clr = 1; @(negedge clk); perr_sts_clr = 0;
    chk("R8", perr_sts, 0);

    // R9: hot reset follows stored bit
    wr_ctl(16'h0040);
    chk("R9", hot_rst_req, 1);
    repeat (4) @(negedge clk);
    chk("R9", hot_rst_req, 1);
    wr_ctl(16'h0000);
    chk("R9", hot_rst_req, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule